// File: doc/BRIEF.md
# AFSK Tone Modulator with Bit Stuffing

This block turns a stream of bytes into audio-frequency shift keyed samples for a 1200 baud link. It pulls bytes from a ready/valid source and sends each one least significant bit first. A 0 bit is sent as a change of tone and a 1 bit as no change (NRZI). A long run of ones inside data is broken with an extra tone change. Every transmission starts with a configurable run of flag bytes and ends with another.

Tones come from a 9-bit phase accumulator that feeds a sine lookup. Only one quarter of the wave is stored. On each pulse of the sample strobe the block emits one unsigned 8-bit sample for a downstream DAC. A byte that arrives while the block is idle starts a transmission, and `busy` stays high until the last trailer flag has been sent. An escape byte makes the byte after it go out literally, with stuffing. This lets flag-valued bytes pass through as data.

Top module: `afsk_tone_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, `sample_out` is 128 and `in_ready` is 1.
- R2: On each strobe while busy, the phase moves forward by the current increment modulo 512. The sample is the quarter-wave entry q(i) = 128 + floor(127.5·sin(2πi/512)), accurate to within 1 LSB, for i from 0 to 127. Within each half wave a position h of 128 or more uses entry 255−h. In the upper half of the wave the sample is 255 minus the entry. Between strobes the sample holds its value.
- R3: A byte accepted while idle raises `busy` one cycle later. It also selects the mark increment and clears the phase and the ones count. The mark increment is round(512·1200/SAMPLE_HZ) and the space increment is round(512·2200/SAMPLE_HZ), which gives 64 and 117 at 9600 Hz. Every bit time, stuffed bits included, lasts SAMPLE_HZ/1200 strobes.
- R4: A 0 data bit swaps the increment between mark and space. A 1 data bit keeps the increment.
- R5: In a stuffable byte, once five ones in a row have been sent, the next bit time carries an inserted tone change (a stuffed 0). The count is then cleared, and the pending data bit is sent in the bit time after that.
- R6: Bytes equal to the flag 0x7E or the abort pattern 0x7F that are taken from the input are sent without stuffing. Loading any byte after an unstuffed one clears the ones count.
- R7: An escape byte 0x1B is not sent. The byte after it is sent literally and stuffed, even when it is 0x7E or 0x7F.
- R8: If no byte is waiting after an escape byte, transmission stops at that bit boundary and no trailer is sent.
- R9: Before the first input byte, the block sends `cfg_preamble` flag bytes 0x7E without stuffing. The count is taken when the transmission starts.
- R10: At a byte boundary with no byte waiting, the block sends a trailer flag for as long as the trailer count is not zero. When the count is zero, `busy` falls on that strobe and the sample returns to 128.
- R11: Every accepted byte reloads the trailer count from `cfg_trailer`. A byte that arrives during the trailer is sent after the flag in progress, followed by a full trailer, and no new preamble is sent.
- R12: Bits leave each byte least significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Byte offered by the source |
| in_valid | input | 1 | Source has a byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| cfg_preamble | input | CNT_W | Number of leading flags |
| cfg_trailer | input | CNT_W | Number of closing flags |
| sample_stb | input | 1 | One pulse per output sample |
| sample_out | output | 8 | Unsigned audio sample |
| busy | output | 1 | Transmission in progress |

## Verification
A wrong increment or a missed NRZI toggle changes the slope of the sine within one bit time, that is within eight samples, and every sample after it moves off the expected phase. A stray or missing stuffed bit, escape or flag shifts the whole later waveform by one bit time or by one byte. It also changes the strobe on which `busy` falls, so the sample count of each frame exposes it. A trailer count that is reloaded or decremented at the wrong time only shows as a transmission that is longer or shorter by whole multiples of 64 samples.

// File: rtl/afsk_tone_tx.sv
module afsk_tone_tx #(
  parameter int          SAMPLE_HZ  = 9600,
  parameter int          BAUD       = 1200,
  parameter int          MARK_HZ    = 1200,
  parameter int          SPACE_HZ   = 2200,
  parameter int          STUFF_RUN  = 5,
  parameter int          CNT_W      = 8,
  parameter logic [7:0]  FLAG_BYTE  = 8'h7E,
  parameter logic [7:0]  ABORT_BYTE = 8'h7F,
  parameter logic [7:0]  ESC_BYTE   = 8'h1B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CNT_W-1:0] cfg_preamble,
  input  logic [CNT_W-1:0] cfg_trailer,
  input  logic             sample_stb,
  output logic [7:0]       sample_out,
  output logic             busy
);

  localparam int WAVE = 512;
  localparam int SPB  = SAMPLE_HZ / BAUD;
  localparam int SC_W = (SPB > 1) ? $clog2(SPB) : 1;
  localparam logic [8:0] MARK_INC  = 9'((WAVE * MARK_HZ + SAMPLE_HZ / 2) / SAMPLE_HZ);
  localparam logic [8:0] SPACE_INC = 9'((WAVE * SPACE_HZ + SAMPLE_HZ / 2) / SAMPLE_HZ);
  localparam longint ROT_C = 64'sd1073660973;
  localparam longint ROT_S = 64'sd13176464;

  if (SAMPLE_HZ % BAUD != 0) begin : g_bad_rate
    $error("sample rate must be a whole multiple of the baud rate");
  end

  function automatic logic [1023:0] build_quarter();
    logic [1023:0] t;
    longint s, c, ns;
    t = '0;
    s = 0;
    c = 64'sd1 <<< 30;
    for (int i = 0; i < 128; i++) begin
      t[i*8 +: 8] = 8'(128 + ((s * 255) >>> 31));
      ns = (s * ROT_C + c * ROT_S) >>> 30;
      c  = (c * ROT_C - s * ROT_S) >>> 30;
      s  = ns;
    end
    return t;
  endfunction

  localparam logic [1023:0] QUARTER = build_quarter();

  function automatic logic [7:0] wave_at(input logic [8:0] ph);
    logic [6:0] q;
    logic [7:0] v;
    q = ph[7] ? ~ph[6:0] : ph[6:0];
    v = QUARTER[{q, 3'b000} +: 8];
    return ph[8] ? ~v : v;
  endfunction

  function automatic logic [8:0] other_tone(input logic [8:0] cur);
    return (cur == MARK_INC) ? SPACE_INC : MARK_INC;
  endfunction

  logic             busy_q, n_busy;
  logic [8:0]       phase, n_phase, inc, n_inc;
  logic [SC_W-1:0]  scnt, n_scnt;
  logic [3:0]       bits_left, n_bits, ones, n_ones;
  logic [7:0]       shreg, n_sh, samp, n_samp;
  logic             stuff_on, n_stuff, halt;
  logic [CNT_W-1:0] pre_left, n_pre, trl_left, n_trl;
  logic [7:0]       h0, h1, n_h0, n_h1;
  logic [1:0]       hcnt, n_hcnt, pop, after_cnt;
  logic             in_fire;

  assign busy       = busy_q;
  assign sample_out = samp;
  assign in_ready   = (hcnt != 2'd2);
  assign in_fire    = in_valid && in_ready;

  always_comb begin
    n_busy  = busy_q;
    n_phase = phase;
    n_inc   = inc;
    n_scnt  = scnt;
    n_bits  = bits_left;
    n_ones  = ones;
    n_sh    = shreg;
    n_samp  = samp;
    n_stuff = stuff_on;
    n_pre   = pre_left;
    n_trl   = trl_left;
    pop     = 2'd0;
    halt    = 1'b0;

    if (busy_q && sample_stb) begin
      if (scnt == '0) begin
        if (bits_left == 4'd0) begin
          if (hcnt == 2'd0 && trl_left == '0) begin
            halt = 1'b1;
          end else begin
            if (!stuff_on) n_ones = 4'd0;
            n_stuff = 1'b1;
            if (pre_left != '0) begin
              n_pre   = pre_left - 1'b1;
              n_sh    = FLAG_BYTE;
              n_stuff = 1'b0;
            end else if (hcnt == 2'd0) begin
              n_trl   = trl_left - 1'b1;
              n_sh    = FLAG_BYTE;
              n_stuff = 1'b0;
            end else begin
              pop = 2'd1;
              if (h0 == ESC_BYTE) begin
                if (hcnt < 2'd2) begin
                  halt = 1'b1;
                end else begin
                  pop  = 2'd2;
                  n_sh = h1;
                end
              end else begin
                n_sh = h0;
                if (h0 == FLAG_BYTE || h0 == ABORT_BYTE) n_stuff = 1'b0;
              end
            end
            n_bits = 4'd8;
          end
        end
        if (!halt) begin
          n_scnt = SC_W'(SPB - 1);
          if (n_stuff && n_ones >= 4'(STUFF_RUN)) begin
            n_ones = 4'd0;
            n_inc  = other_tone(inc);
          end else begin
            if (n_sh[0]) begin
              if (n_ones != 4'hF) n_ones = n_ones + 4'd1;
            end else begin
              n_ones = 4'd0;
              n_inc  = other_tone(inc);
            end
            n_sh   = {1'b0, n_sh[7:1]};
            n_bits = n_bits - 4'd1;
          end
        end
      end else begin
        n_scnt = scnt - 1'b1;
      end

      if (halt) begin
        n_busy = 1'b0;
        n_samp = 8'd128;
      end else begin
        n_phase = phase + n_inc;
        n_samp  = wave_at(n_phase);
      end
    end

    if (!busy_q && in_fire) begin
      n_busy  = 1'b1;
      n_phase = 9'd0;
      n_inc   = MARK_INC;
      n_ones  = 4'd0;
      n_scnt  = '0;
      n_bits  = 4'd0;
      n_stuff = 1'b0;
      n_pre   = cfg_preamble;
    end
    if (in_fire) n_trl = cfg_trailer;
  end

  always_comb begin
    n_h0      = h0;
    n_h1      = h1;
    after_cnt = hcnt;
    if (pop == 2'd1) begin
      n_h0      = h1;
      after_cnt = hcnt - 2'd1;
    end else if (pop == 2'd2) begin
      after_cnt = 2'd0;
    end
    n_hcnt = after_cnt;
    if (in_fire) begin
      if (after_cnt == 2'd0) n_h0 = in_data;
      else                   n_h1 = in_data;
      n_hcnt = after_cnt + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      phase     <= 9'd0;
      inc       <= MARK_INC;
      scnt      <= '0;
      bits_left <= 4'd0;
      ones      <= 4'd0;
      shreg     <= 8'd0;
      samp      <= 8'd128;
      stuff_on  <= 1'b0;
      pre_left  <= '0;
      trl_left  <= '0;
      h0        <= 8'd0;
      h1        <= 8'd0;
      hcnt      <= 2'd0;
    end else begin
      busy_q    <= n_busy;
      phase     <= n_phase;
      inc       <= n_inc;
      scnt      <= n_scnt;
      bits_left <= n_bits;
      ones      <= n_ones;
      shreg     <= n_sh;
      samp      <= n_samp;
      stuff_on  <= n_stuff;
      pre_left  <= n_pre;
      trl_left  <= n_trl;
      h0        <= n_h0;
      h1        <= n_h1;
      hcnt      <= n_hcnt;
    end
  end

endmodule

// File: rtl/afsk_tone_tx_chk.sv
module afsk_tone_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       sample_stb,
  input logic       busy,
  input logic [7:0] sample_out
);

  a_r1_idle_midscale: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sample_out == 8'd128);

  a_r1_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> in_ready);

  a_r2_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample_stb) |-> $stable(sample_out));

  a_r3_start_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && in_valid && in_ready) |=> busy);

  a_r10_stop_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(sample_stb));

endmodule

bind afsk_tone_tx afsk_tone_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .sample_stb (sample_stb),
  .busy       (busy),
  .sample_out (sample_out)
);

// File: tb/tb_afsk_tone_tx.sv
`timescale 1ns/1ps
module tb_afsk_tone_tx;

  localparam int MARK  = 64;
  localparam int SPACE = 117;
  localparam int SPB   = 8;
  localparam real PI   = 3.14159265358979;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid, in_ready, stb = 1'b0, busy;
  logic [7:0] in_data, sample_out;
  logic [7:0] cfg_pre = 8'd0, cfg_trl = 8'd0;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] qbuf [256];
  int qn = 0, qi = 0;

  int exp_inc [1024];
  int nexp;
  logic [7:0] cur_b [4];

  // {preamble, trailer, count, byte0..byte3}
  localparam logic [55:0] VEC [7] = '{
    {8'd1, 8'd1, 8'd1, 8'h00, 8'h00, 8'h00, 8'h00},   // R4 R9 R12
    {8'd0, 8'd1, 8'd2, 8'hFF, 8'h01, 8'h00, 8'h00},   // R5 R12
    {8'd1, 8'd1, 8'd2, 8'h1B, 8'h7E, 8'h00, 8'h00},   // R7
    {8'd0, 8'd1, 8'd2, 8'h7F, 8'hF8, 8'h00, 8'h00},   // R6
    {8'd2, 8'd2, 8'd2, 8'h55, 8'hAA, 8'h00, 8'h00},   // R9 R10
    {8'd0, 8'd0, 8'd2, 8'h41, 8'h1B, 8'h00, 8'h00},   // R8
    {8'd0, 8'd0, 8'd1, 8'h3E, 8'h00, 8'h00, 8'h00}    // R5 R10
  };

  function automatic string vec_tag(input int v);
    case (v)
      0: return "R4/NRZI zeros";
      1: return "R5/stuffing";
      2: return "R7/escape";
      3: return "R6/unstuffed abort";
      4: return "R9/preamble";
      5: return "R8/escape at end";
      default: return "R5/zero trailer";
    endcase
  endfunction

  assign in_valid = (qi < qn);
  assign in_data  = qbuf[qi[7:0]];

  always @(posedge clk) if (in_valid && in_ready) qi <= qi + 1;

  always #2.5 clk = ~clk;

  afsk_tone_tx dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .cfg_preamble(cfg_pre), .cfg_trailer(cfg_trl),
    .sample_stb(stb), .sample_out(sample_out), .busy(busy)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int ref_sample(input int p);
    int h, q, v;
    h = p % 256;
    q = (h >= 128) ? 255 - h : h;
    v = 128 + int'($floor(127.5 * $sin(2.0 * PI * q / 512.0)));
    return (p >= 256) ? 255 - v : v;
  endfunction

  task automatic strobe();
    @(negedge clk) stb = 1'b1;
    @(negedge clk) stb = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    qbuf[qn[7:0]] = b;
    qn++;
  endtask

  task automatic build_exp(input int pre, input int trl, input int nb);
    logic [7:0] items [16];
    bit stf [16];
    int ni, k, inc, ones;
    bit st, esc_stop;
    ni = 0; esc_stop = 0; k = 0;
    for (int j = 0; j < pre; j++) begin items[ni] = 8'h7E; stf[ni] = 0; ni++; end
    while (k < nb && !esc_stop) begin
      if (cur_b[k] == 8'h1B) begin
        if (k + 1 < nb) begin items[ni] = cur_b[k+1]; stf[ni] = 1; ni++; k += 2; end
        else esc_stop = 1;
      end else begin
        items[ni] = cur_b[k];
        stf[ni] = !(cur_b[k] == 8'h7E || cur_b[k] == 8'h7F);
        ni++; k++;
      end
    end
    if (!esc_stop)
      for (int j = 0; j < trl; j++) begin items[ni] = 8'h7E; stf[ni] = 0; ni++; end
    inc = MARK; ones = 0; st = 0; nexp = 0;
    for (int it = 0; it < ni; it++) begin
      if (!st) ones = 0;
      st = stf[it];
      for (int b = 0; b < 8; b++) begin
        if (st && ones >= 5) begin
          ones = 0;
          inc = (inc == MARK) ? SPACE : MARK;
          exp_inc[nexp] = inc; nexp++;
        end
        if (items[it][b]) ones++;
        else begin ones = 0; inc = (inc == MARK) ? SPACE : MARK; end
        exp_inc[nexp] = inc; nexp++;
      end
    end
  endtask

  task automatic run_vec(input int v);
    int pre, trl, nb, phase, mism, first_act, first_exp, e, held;
    pre = int'(VEC[v][55:48]);
    trl = int'(VEC[v][47:40]);
    nb  = int'(VEC[v][39:32]);
    for (int j = 0; j < 4; j++) cur_b[j] = VEC[v][31-8*j -: 8];
    @(negedge clk);
    cfg_pre = VEC[v][55:48];
    cfg_trl = VEC[v][47:40];
    for (int j = 0; j < nb; j++) push(cur_b[j]);
    build_exp(pre, trl, nb);
    repeat (6) @(negedge clk);
    chk(busy == 1'b1, {"R3 busy after accept, ", vec_tag(v)}, int'(busy), 1);
    phase = 0; mism = 0; first_act = 0; first_exp = 0;
    for (int s = 0; s < nexp * SPB; s++) begin
      strobe();
      phase = (phase + exp_inc[s / SPB]) % 512;
      e = ref_sample(phase);
      if (!busy || int'(sample_out) > e + 1 || int'(sample_out) < e - 1) begin
        if (mism == 0) begin first_act = int'(sample_out); first_exp = e; end
        mism++;
      end
      if (v == 0 && s == 3) begin
        held = int'(sample_out);
        repeat (6) @(negedge clk);
        chk(int'(sample_out) == held, "R2 sample held between strobes", int'(sample_out), held);
      end
    end
    chk(mism == 0, {"R2 waveform, ", vec_tag(v)}, first_act, first_exp);
    strobe();
    chk(busy == 1'b0, {"R10 busy falls after last bit, ", vec_tag(v)}, int'(busy), 0);
    chk(sample_out == 8'd128, {"R1 mid-scale after stop, ", vec_tag(v)}, int'(sample_out), 128);
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    chk(sample_out == 8'd128, "R1 sample after reset", int'(sample_out), 128);

    for (int v = 0; v < 7; v++) run_vec(v);

    // R11: byte arrives during the first trailer flag; 2 pre + 1 byte + rest of flag + byte + 3 flags
    @(negedge clk);
    cfg_pre = 8'd2;
    cfg_trl = 8'd3;
    push(8'h00);
    repeat (6) @(negedge clk);
    n = 0;
    while (busy && n < 2000) begin
      strobe();
      n++;
      if (n == 3 * 64 + 20) push(8'h00);
    end
    chk(n == 8 * 64 + 1, "R11 trailer re-armed without preamble", n, 8 * 64 + 1);

    summary();
  end

endmodule